// File: doc/BRIEF.md
# Line-to-Message Interrupt Redirection Controller

This block turns a set of wired interrupt inputs into message writes. Each input line owns a redirection entry that gives its input polarity, whether it is edge- or level-sensitive, whether it is masked, the data byte the message carries and the 16-bit destination the message goes to. When an unmasked line fires, the block raises a message on a valid/ready output carrying that destination and data byte.

Software reaches the entries indirectly. It writes an index into a select register and then reads or writes a window register, which maps onto the register at that index. A read of the window always returns the current contents, so software can read back after an entry write to make sure the write has landed. A level-sensitive line delivers once and then stays blocked until software writes the line's data byte to the end-of-interrupt register. If the line is still asserted at that point, the message is sent again.

The message output follows valid/ready rules. Once `msg_valid` rises, `msg_dest` and `msg_data` stay fixed until a cycle in which `msg_ready` is high. The message counts as taken at that edge. While a message waits for ready, the block launches no other message.

Top module: `msg_irq_redirector`

## Requirements
- R1: Byte offset 0x00 is the select register, 0x10 is the window and 0x40 is end-of-interrupt. The select reads back its last written byte and resets to 0. Every entry resets to low word 0x0001_0000 (masked) and high word 0. A window index that selects nothing reads 0 and ignores writes.
- R2: Index 0x01 is read-only. It returns the version byte (default 0x21) in bits 7:0 and NUM_LINES-1 in bits 23:16. Writes to it have no effect.
- R3: Line n's low word is at index 0x10+2n and its high word is at index 0x11+2n. The low word keeps these fields: bits 7:0 data, bit 8 lowest-priority flag (stored only), bit 13 active-low, bit 15 level mode and bit 16 mask. The high word keeps bits 31:16, split as ID 31:24 and extended ID 23:16. All other bits read 0. A message carries `msg_dest` = high word bits 31:16 and `msg_data` = low word bits 7:0.
- R4: A masked line produces no message. An edge that occurs while the line is masked is not recorded, so unmasking afterwards produces nothing.
- R5: An unmasked edge-mode line produces exactly one message per rising edge of its polarity-adjusted input, however long the input stays high.
- R6: With the active-low bit set, a line is asserted when its input is 0.
- R7: An unmasked level-mode line sends one message while asserted and is then blocked. A write of value v to offset 0x40 unblocks every level line whose data byte equals v, and a line that is still asserted sends again. An end-of-interrupt write with a different value has no effect.
- R8: When several lines are ready to send, the lowest-numbered line goes first.
- R9: While `msg_valid` is high and `msg_ready` is low, `msg_valid`, `msg_dest` and `msg_data` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| irq_in | input | NUM_LINES | Raw interrupt input lines |
| msg_valid | output | 1 | Message available |
| msg_ready | input | 1 | Consumer takes the message |
| msg_dest | output | 16 | Message destination (ID, extended ID) |
| msg_data | output | 8 | Message data byte |

## Verification
The case that needs care is arbitration coinciding with back-pressure. The bench creates it by raising two edge lines in the same cycle while `msg_ready` is low. The lower line must be the one latched, and it must then hold unchanged for several stalled cycles while the higher line waits as pending. The scoreboard requires the two messages to arrive in line order once ready returns, and the per-cycle samples during the stall confirm that the held destination does not move.

// File: rtl/irq_redir_pkg.sv
package irq_redir_pkg;
  localparam int REG_W      = 32;
  localparam int ADDR_W     = 8;
  localparam int IDX_W      = 8;
  localparam int MSG_DATA_W = 8;
  localparam int DEST_W     = 16;

  // byte offsets of the bus-visible registers
  localparam logic [ADDR_W-1:0] OFF_SEL = 8'h00;
  localparam logic [ADDR_W-1:0] OFF_WIN = 8'h10;
  localparam logic [ADDR_W-1:0] OFF_EOI = 8'h40;

  // internal indices behind the window
  localparam logic [IDX_W-1:0] IDX_VER      = 8'h01;
  localparam int               IDX_ENT_BASE = 16'h10;

  // low word field positions
  localparam int LPRI_BIT = 8;
  localparam int POL_BIT  = 13;
  localparam int LVL_BIT  = 15;
  localparam int MASK_BIT = 16;
  // high word destination position
  localparam int DEST_LSB = 16;
endpackage

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  output logic [N-1:0] grant,
  output logic         any
);
  // isolate lowest set bit: lowest line number wins
  assign grant = req & (~req + N'(1));
  assign any   = |req;

  assert_lowest_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
    any |-> ($onehot(grant) && ((grant & ~req) == '0) && (((grant - N'(1)) & req) == '0)));
endmodule

// File: rtl/irq_line_unit.sv
module irq_line_unit
  import irq_redir_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_lo,
  input  logic                  wr_hi,
  input  logic [MSG_DATA_W-1:0] lo_data_wd,
  input  logic                  lo_lpri_wd,
  input  logic                  lo_pol_wd,
  input  logic                  lo_lvl_wd,
  input  logic                  lo_mask_wd,
  input  logic [DEST_W-1:0]     hi_dest_wd,
  input  logic                  eoi_wr,
  input  logic [MSG_DATA_W-1:0] eoi_val,
  input  logic                  irq_raw,
  input  logic                  launch,
  output logic                  req_o,
  output logic [REG_W-1:0]      lo_rd,
  output logic [REG_W-1:0]      hi_rd,
  output logic [MSG_DATA_W-1:0] data_o,
  output logic [DEST_W-1:0]     dest_o
);
  logic [MSG_DATA_W-1:0] data_q;
  logic [DEST_W-1:0]     dest_q;
  logic mask_q, pol_q, lvl_q, lpri_q;
  logic act, act_d, edge_ev, pend_q, insvc_q, eoi_hit;

  assign act     = irq_raw ^ pol_q;
  assign edge_ev = act & ~act_d & ~mask_q & ~lvl_q;
  assign eoi_hit = eoi_wr & lvl_q & (eoi_val == data_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q  <= '0;
      dest_q  <= '0;
      mask_q  <= 1'b1;
      pol_q   <= 1'b0;
      lvl_q   <= 1'b0;
      lpri_q  <= 1'b0;
      act_d   <= 1'b0;
      pend_q  <= 1'b0;
      insvc_q <= 1'b0;
    end else begin
      if (wr_lo) begin
        data_q <= lo_data_wd;
        lpri_q <= lo_lpri_wd;
        pol_q  <= lo_pol_wd;
        lvl_q  <= lo_lvl_wd;
        mask_q <= lo_mask_wd;
      end
      if (wr_hi) dest_q <= hi_dest_wd;
      act_d  <= act;
      // set wins so an edge arriving at launch time queues another message
      pend_q <= (pend_q & ~launch) | edge_ev;
      if (launch && lvl_q)  insvc_q <= 1'b1;
      else if (eoi_hit)     insvc_q <= 1'b0;
    end
  end

  assign req_o  = lvl_q ? (act & ~mask_q & ~insvc_q) : (pend_q & ~mask_q);
  assign data_o = data_q;
  assign dest_o = dest_q;

  always_comb begin
    lo_rd                   = '0;
    lo_rd[MSG_DATA_W-1:0]   = data_q;
    lo_rd[LPRI_BIT]         = lpri_q;
    lo_rd[POL_BIT]          = pol_q;
    lo_rd[LVL_BIT]          = lvl_q;
    lo_rd[MASK_BIT]         = mask_q;
    hi_rd                   = '0;
    hi_rd[DEST_LSB +: DEST_W] = dest_q;
  end

  assert_masked_no_record_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q && !pend_q) |=> !pend_q);
  assert_level_blocked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (launch && lvl_q && !wr_lo) |=> !req_o);
  assert_edge_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (launch && !lvl_q && !edge_ev) |=> !pend_q);
endmodule

// File: rtl/msg_irq_redirector.sv
module msg_irq_redirector
  import irq_redir_pkg::*;
#(
  parameter int          NUM_LINES = 4,
  parameter logic [7:0]  VERSION   = 8'h21
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  reg_wr,
  input  logic [ADDR_W-1:0]     reg_addr,
  input  logic [REG_W-1:0]      reg_wdata,
  output logic [REG_W-1:0]      reg_rdata,
  input  logic [NUM_LINES-1:0]  irq_in,
  output logic                  msg_valid,
  input  logic                  msg_ready,
  output logic [DEST_W-1:0]     msg_dest,
  output logic [MSG_DATA_W-1:0] msg_data
);
  localparam logic [7:0] MAX_ENTRY = 8'(NUM_LINES - 1);

  logic [IDX_W-1:0]     sel_q;
  logic                 win_wr, eoi_wr;
  logic [NUM_LINES-1:0] wr_lo, wr_hi, req, grant, launch;
  logic                 any_req;
  logic [REG_W-1:0]     lo_v [NUM_LINES];
  logic [REG_W-1:0]     hi_v [NUM_LINES];
  logic [MSG_DATA_W-1:0] data_v [NUM_LINES];
  logic [DEST_W-1:0]    dest_v [NUM_LINES];
  logic [REG_W-1:0]     win_rd;
  logic [DEST_W-1:0]    pick_dest;
  logic [MSG_DATA_W-1:0] pick_data;
  logic                 unused_wbits;

  assign unused_wbits = ^{reg_wdata[14], reg_wdata[12:9]};

  assign win_wr = reg_wr && (reg_addr == OFF_WIN);
  assign eoi_wr = reg_wr && (reg_addr == OFF_EOI);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                sel_q <= '0;
    else if (reg_wr && (reg_addr == OFF_SEL))  sel_q <= reg_wdata[IDX_W-1:0];
  end

  for (genvar n = 0; n < NUM_LINES; n++) begin : g_line
    assign wr_lo[n] = win_wr && (sel_q == IDX_W'(IDX_ENT_BASE + 2*n));
    assign wr_hi[n] = win_wr && (sel_q == IDX_W'(IDX_ENT_BASE + 2*n + 1));

    irq_line_unit u_line (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_lo      (wr_lo[n]),
      .wr_hi      (wr_hi[n]),
      .lo_data_wd (reg_wdata[MSG_DATA_W-1:0]),
      .lo_lpri_wd (reg_wdata[LPRI_BIT]),
      .lo_pol_wd  (reg_wdata[POL_BIT]),
      .lo_lvl_wd  (reg_wdata[LVL_BIT]),
      .lo_mask_wd (reg_wdata[MASK_BIT]),
      .hi_dest_wd (reg_wdata[DEST_LSB +: DEST_W]),
      .eoi_wr     (eoi_wr),
      .eoi_val    (reg_wdata[MSG_DATA_W-1:0]),
      .irq_raw    (irq_in[n]),
      .launch     (launch[n]),
      .req_o      (req[n]),
      .lo_rd      (lo_v[n]),
      .hi_rd      (hi_v[n]),
      .data_o     (data_v[n]),
      .dest_o     (dest_v[n])
    );
  end

  // window readback: version, one entry word, or zero
  always_comb begin
    win_rd = '0;
    if (sel_q == IDX_VER) win_rd = {8'h00, MAX_ENTRY, 8'h00, VERSION};
    for (int n = 0; n < NUM_LINES; n++) begin
      if (sel_q == IDX_W'(IDX_ENT_BASE + 2*n))     win_rd = lo_v[n];
      if (sel_q == IDX_W'(IDX_ENT_BASE + 2*n + 1)) win_rd = hi_v[n];
    end
  end

  always_comb begin
    case (reg_addr)
      OFF_SEL: reg_rdata = {{(REG_W-IDX_W){1'b0}}, sel_q};
      OFF_WIN: reg_rdata = win_rd;
      default: reg_rdata = '0;
    endcase
  end

  irq_prio_pick #(.N(NUM_LINES)) u_pick (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (req),
    .grant (grant),
    .any   (any_req)
  );

  assign launch = msg_valid ? '0 : grant;

  always_comb begin
    pick_dest = '0;
    pick_data = '0;
    for (int n = 0; n < NUM_LINES; n++) begin
      if (grant[n]) begin
        pick_dest = pick_dest | dest_v[n];
        pick_data = pick_data | data_v[n];
      end
    end
  end

  // single output register; new capture only when the slot is empty
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msg_valid <= 1'b0;
      msg_dest  <= '0;
      msg_data  <= '0;
    end else if (msg_valid) begin
      if (msg_ready) msg_valid <= 1'b0;
    end else if (any_req) begin
      msg_valid <= 1'b1;
      msg_dest  <= pick_dest;
      msg_data  <= pick_data;
    end
  end

  assert_stall_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_dest) && $stable(msg_data)));
endmodule

// File: tb/tb_msg_irq_redirector.sv
`timescale 1ns/1ps
module tb_msg_irq_redirector;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [3:0]  irq_in = 4'b0010;
  logic        msg_valid;
  logic        msg_ready = 1'b1;
  logic [15:0] msg_dest;
  logic [7:0]  msg_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [23:0] exp_q [$];
  string       tag_q [$];

  always #10 clk = ~clk;

  msg_irq_redirector dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_in(irq_in),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_dest(msg_dest), .msg_data(msg_data)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_chk(string tag, logic [7:0] a, logic [31:0] exp);
    reg_addr = a;
    #1;
    chk(tag, reg_rdata, exp);
  endtask

  task automatic win_chk(string tag, logic [7:0] idx, logic [31:0] exp);
    wr(8'h00, {24'h0, idx});
    rd_chk(tag, 8'h10, exp);
  endtask

  task automatic set_entry(int line, logic [31:0] lo, logic [31:0] hi);
    wr(8'h00, 32'(8'h10 + 2*line));
    wr(8'h10, lo);
    wr(8'h00, 32'(8'h11 + 2*line));
    wr(8'h10, hi);
  endtask

  task automatic expect_msg(string tag, logic [15:0] d, logic [7:0] v);
    exp_q.push_back({d, v});
    tag_q.push_back(tag);
  endtask

  task automatic drained(string tag);
    checks++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL %s actual=%0d pending expected=0", tag, exp_q.size());
      exp_q.delete();
      tag_q.delete();
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    logic [23:0] e;
    string t;
    if (rst_n && msg_valid && msg_ready) begin
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL unexpected message actual=%h expected=none", {msg_dest, msg_data});
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if ({msg_dest, msg_data} !== e) begin
          fails++;
          $display("FAIL %s actual=%h expected=%h", t, {msg_dest, msg_data}, e);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);
    // R1 reset state
    rd_chk("R1 select reset", 8'h00, 32'h0);
    chk("R1 no message after reset", {31'h0, msg_valid}, 32'h0);
    win_chk("R1 entry0 low reset masked", 8'h10, 32'h0001_0000);
    win_chk("R1 entry3 high reset", 8'h17, 32'h0);
    rd_chk("R1 select readback", 8'h00, 32'h17);
    win_chk("R1 unused index reads zero", 8'h05, 32'h0);
    wr(8'h10, 32'hFFFF_FFFF);
    rd_chk("R1 unused index write ignored", 8'h10, 32'h0);
    // R2 version
    win_chk("R2 version", 8'h01, 32'h0003_0021);
    wr(8'h10, 32'h1234_5678);
    rd_chk("R2 version read-only", 8'h10, 32'h0003_0021);
    // R3 programming and layout
    set_entry(0, 32'h0000_5141, 32'hAB12_FFFF);
    win_chk("R3 low word fields", 8'h10, 32'h0000_0141);
    win_chk("R3 high word fields", 8'h11, 32'hAB12_0000);
    set_entry(1, 32'h0000_2052, 32'h0102_0000);
    win_chk("R3 polarity bit", 8'h12, 32'h0000_2052);
    set_entry(2, 32'h0000_8063, 32'h0203_0000);
    set_entry(3, 32'h0001_8074, 32'h0304_0000);
    idle(4);
    drained("R7 level line idle when deasserted");
    // R5 edge
    expect_msg("R5 edge pulse", 16'hAB12, 8'h41);
    irq_in[0] = 1'b1; idle(1); irq_in[0] = 1'b0;
    idle(6);
    drained("R5 edge pulse delivered");
    expect_msg("R5 long edge once", 16'hAB12, 8'h41);
    irq_in[0] = 1'b1; idle(8); irq_in[0] = 1'b0;
    idle(4);
    drained("R5 single message per edge");
    // R6 active-low
    expect_msg("R6 active-low line", 16'h0102, 8'h52);
    irq_in[1] = 1'b0; idle(5); irq_in[1] = 1'b1;
    idle(5);
    drained("R6 active-low delivered once");
    // R4 masked edge not recorded
    set_entry(0, 32'h0001_0041, 32'hAB12_0000);
    irq_in[0] = 1'b1; idle(2); irq_in[0] = 1'b0;
    idle(2);
    wr(8'h00, 32'h10);
    wr(8'h10, 32'h0000_0041);
    idle(6);
    drained("R4 masked edge not recorded");
    // R4/R7 masked level then unmask
    irq_in[3] = 1'b1;
    idle(6);
    drained("R4 masked level silent");
    expect_msg("R7 level on unmask", 16'h0304, 8'h74);
    wr(8'h00, 32'h16);
    wr(8'h10, 32'h0000_8074);
    idle(6);
    drained("R7 level delivered once then blocked");
    wr(8'h40, 32'h63);
    idle(6);
    drained("R7 non-matching eoi no effect");
    expect_msg("R7 eoi resend", 16'h0304, 8'h74);
    wr(8'h40, 32'h74);
    idle(6);
    drained("R7 eoi resend delivered");
    irq_in[3] = 1'b0;
    idle(1);
    wr(8'h40, 32'h74);
    idle(6);
    drained("R7 eoi after deassert silent");
    // R7 line 2
    expect_msg("R7 level line2", 16'h0203, 8'h63);
    irq_in[2] = 1'b1;
    idle(6);
    expect_msg("R7 line2 eoi resend", 16'h0203, 8'h63);
    wr(8'h40, 32'h63);
    idle(6);
    irq_in[2] = 1'b0;
    wr(8'h40, 32'h63);
    idle(6);
    drained("R7 line2 sequence");
    // R8 + R9: simultaneous edges under stall
    msg_ready = 1'b0;
    expect_msg("R8 lower line first", 16'hAB12, 8'h41);
    expect_msg("R8 higher line second", 16'h0102, 8'h52);
    irq_in[0] = 1'b1; irq_in[1] = 1'b0;
    idle(3);
    for (int i = 0; i < 3; i++) begin
      chk("R9 valid held under stall", {31'h0, msg_valid}, 32'h1);
      chk("R9 dest held under stall", {16'h0, msg_dest}, 32'h0000_AB12);
      idle(1);
    end
    msg_ready = 1'b1;
    idle(6);
    irq_in[0] = 1'b0; irq_in[1] = 1'b1;
    idle(4);
    drained("R8 both messages delivered in order");
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule